// File: doc/BRIEF.md
# Two-Channel Wrap Timer

This block is a timer peripheral with two independent channels. Each channel keeps a 16-bit up-counter that advances on its own count clock. That clock may share a source with the bus clock or be fully asynchronous to it. A four-bit code per channel sets a power-of-two division of the count clock, from /2 up to /256.

Each channel counts from zero up to a programmable reload value, then returns to zero. At that wrap it raises a status bit and an interrupt line. Software clears the status bit by writing a one to it.

The register port follows the simple APB access pattern: a setup cycle, then an access cycle. The port never stalls. Each wrap leaves the count domain as a toggle that the bus domain synchronises, so a wrap is never lost and never counted twice. The status bits live entirely in the bus domain, so a clear takes effect at once. A wrap that lands in the same bus cycle as a clear wins over the clear.

Top module: `gpt_dual_timer`

## Requirements
- R1: After reset, every register reads zero and both interrupt lines are low.
- R2: Channel c has a register block at byte offset 16*c with these registers:
  - +0x0 control: bit 0 enable, bit 1 one-shot.
  - +0x4 prescale code in bits 3:0.
  - +0x8 reload value in bits 15:0.
  - +0xC live count, read only; writes to it are ignored.
  - Register bits outside these fields read zero, and unmapped addresses read zero.
- R3: With the channel enabled, the counter steps 0,1,...,reload,0 and sets status bit c at every wrap to zero. The wrap period is (reload+1)*2^(code+1) count-clock cycles.
- R4: Prescale codes 8 to 15 divide by 256, the same as code 7.
- R5: The status register is at byte 0x20, with bit c belonging to channel c. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. irq[c] equals status bit c.
- R6: A wrap that reaches the bus domain in the same cycle as a clear of the same bit leaves the bit set.
- R7: In one-shot mode the channel wraps once and then holds its counter at zero with no further wraps. Clearing enable and setting it again re-arms the channel.
- R8: Clearing enable returns the counter to zero and resets the prescaler. A later enable starts a fresh period.
- R9: The two channels are independent, and channel 1 may run on a clock asynchronous to the bus clock without losing or duplicating wraps. Each count clock must run no faster than the bus clock. Prescale and reload may be changed only while the channel is disabled.
- R10: The count register returns the channel counter through a two-stage synchroniser, two bus cycles behind the count domain.
- R11: Every bus cycle with select, enable and write high is a write. pready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 6 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high |
| cnt_clk | input | 2 | Count clock per channel |
| irq | output | 2 | Per-channel wrap interrupt, level |

## Verification
The two functions that can meet in one bus cycle are the arrival of a synchronised wrap and a software clear of the same status bit. The bench drives channel 0 from the bus clock so that this timing is deterministic. A one-shot calibration run measures the exact cycle gap between the enable write and the status set. A sweep then places the clear write from two cycles before that set to two cycles after it. Each outcome is judged against the rule that a clear at or before the set cycle leaves the bit set, and a later clear leaves it cleared.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // Word select within a channel register block (paddr[3:2])
  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_PSC    = 2'd1;
  localparam logic [1:0] REG_RELOAD = 2'd2;
  localparam logic [1:0] REG_COUNT  = 2'd3;

  // Control bit positions
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_OS_BIT = 1;

  typedef struct packed {
    logic oneshot;
    logic enable;
  } chan_ctrl_t;
endpackage

// File: rtl/gpt_sync_vec.sv
module gpt_sync_vec #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gpt_toggle_sync.sv
module gpt_toggle_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic tgl_s;
  logic tgl_d;

  gpt_sync_vec #(.WIDTH(1), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (tgl_in),
    .q    (tgl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_d <= 1'b0;
    else        tgl_d <= tgl_s;
  end

  // one bus-cycle pulse per toggle of the count domain
  assign pulse = tgl_s ^ tgl_d;
endmodule

// File: rtl/gpt_count_chan.sv
module gpt_count_chan
  import gpt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic             cnt_clk,
  input  logic             rst_n,
  input  chan_ctrl_t       ctrl_bus,
  input  logic [PSC_W-1:0] psc_code,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap_tgl,
  output logic             active,
  output logic             halted
);
  localparam int DIV_W = MAX_SHIFT;

  chan_ctrl_t         ctrl_s;
  logic [DIV_W-1:0]   div_q;
  logic [DIV_W-1:0]   div_lim;
  logic               tick;

  gpt_sync_vec #(.WIDTH($bits(chan_ctrl_t)), .STAGES(2)) u_ctrl_sync (
    .clk  (cnt_clk),
    .rst_n(rst_n),
    .d    (ctrl_bus),
    .q    (ctrl_s)
  );

  function automatic logic [DIV_W-1:0] limit_of(input logic [PSC_W-1:0] code);
    int sh;
    sh = int'(code) + 1;
    if (sh > MAX_SHIFT) sh = MAX_SHIFT;
    return DIV_W'((1 << sh) - 1);
  endfunction

  assign div_lim = limit_of(psc_code);
  assign tick    = (div_q == div_lim);
  assign active  = ctrl_s.enable;

  always_ff @(posedge cnt_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      count    <= '0;
      halted   <= 1'b0;
      wrap_tgl <= 1'b0;
    end else if (!ctrl_s.enable) begin
      div_q  <= '0;
      count  <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (tick) begin
        div_q <= '0;
        if (count == reload) begin
          count    <= '0;
          wrap_tgl <= ~wrap_tgl;
          if (ctrl_s.oneshot) halted <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpt_bus_regs.sv
module gpt_bus_regs
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                         pclk,
  input  logic                         rst_n,
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [DATA_W-1:0]            pwdata,
  output logic [DATA_W-1:0]            prdata,
  input  logic [NUM_CH-1:0]            wrap_pulse,
  input  logic [NUM_CH-1:0][CNT_W-1:0] count_sync,
  output chan_ctrl_t [NUM_CH-1:0]      ctrl_q,
  output logic [NUM_CH-1:0][PSC_W-1:0] psc_q,
  output logic [NUM_CH-1:0][CNT_W-1:0] reload_q,
  output logic [NUM_CH-1:0]            status_q,
  output logic [NUM_CH-1:0]            clr_req
);
  localparam int BLK_W = ADDR_W - 4;

  logic             wr_en;
  logic [BLK_W-1:0] blk;
  logic [1:0]       word;
  logic             stat_hit;

  assign wr_en    = psel & penable & pwrite;
  assign blk      = paddr[ADDR_W-1:4];
  assign word     = paddr[3:2];
  assign stat_hit = (blk == BLK_W'(NUM_CH)) && (word == 2'd0);
  assign clr_req  = (wr_en && stat_hit) ? pwdata[NUM_CH-1:0] : '0;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      psc_q    <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (blk == BLK_W'(c)) begin
          case (word)
            REG_CTRL: begin
              ctrl_q[c].enable  <= pwdata[CTRL_EN_BIT];
              ctrl_q[c].oneshot <= pwdata[CTRL_OS_BIT];
            end
            REG_PSC:    psc_q[c]    <= pwdata[PSC_W-1:0];
            REG_RELOAD: reload_q[c] <= pwdata[CNT_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // wrap arrival wins over a clear in the same cycle
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wrap_pulse[c])   status_q[c] <= 1'b1;
        else if (clr_req[c]) status_q[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    prdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (blk == BLK_W'(c)) begin
        case (word)
          REG_CTRL: begin
            prdata[CTRL_EN_BIT] = ctrl_q[c].enable;
            prdata[CTRL_OS_BIT] = ctrl_q[c].oneshot;
          end
          REG_PSC:    prdata[PSC_W-1:0] = psc_q[c];
          REG_RELOAD: prdata[CNT_W-1:0] = reload_q[c];
          default:    prdata[CNT_W-1:0] = count_sync[c];
        endcase
      end
    end
    if (stat_hit) prdata[NUM_CH-1:0] = status_q;
  end
endmodule

// File: rtl/gpt_dual_timer.sv
module gpt_dual_timer
  import gpt_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 4,
  parameter int MAX_SHIFT = 8,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic [NUM_CH-1:0] cnt_clk,
  output logic [NUM_CH-1:0] irq
);
  chan_ctrl_t [NUM_CH-1:0]      ctrl_q;
  logic [NUM_CH-1:0][PSC_W-1:0] psc_q;
  logic [NUM_CH-1:0][CNT_W-1:0] reload_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_val;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_sync;
  logic [NUM_CH-1:0]            wrap_tgl;
  logic [NUM_CH-1:0]            wrap_pulse;
  logic [NUM_CH-1:0]            run_q;
  logic [NUM_CH-1:0]            halt_q;
  logic [NUM_CH-1:0]            status_q;
  logic [NUM_CH-1:0]            clr_req;

  assign pready = 1'b1;
  assign irq    = status_q;

  gpt_bus_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .wrap_pulse(wrap_pulse),
    .count_sync(cnt_sync),
    .ctrl_q    (ctrl_q),
    .psc_q     (psc_q),
    .reload_q  (reload_q),
    .status_q  (status_q),
    .clr_req   (clr_req)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gpt_count_chan #(
      .CNT_W(CNT_W), .PSC_W(PSC_W), .MAX_SHIFT(MAX_SHIFT)
    ) u_chan (
      .cnt_clk (cnt_clk[c]),
      .rst_n   (rst_n),
      .ctrl_bus(ctrl_q[c]),
      .psc_code(psc_q[c]),
      .reload  (reload_q[c]),
      .count   (cnt_val[c]),
      .wrap_tgl(wrap_tgl[c]),
      .active  (run_q[c]),
      .halted  (halt_q[c])
    );

    gpt_toggle_sync u_wrap_sync (
      .clk   (pclk),
      .rst_n (rst_n),
      .tgl_in(wrap_tgl[c]),
      .pulse (wrap_pulse[c])
    );

    gpt_sync_vec #(.WIDTH(CNT_W), .STAGES(2)) u_cnt_sync (
      .clk  (pclk),
      .rst_n(rst_n),
      .d    (cnt_val[c]),
      .q    (cnt_sync[c])
    );
  end
endmodule

// File: rtl/gpt_dual_timer_chk.sv
module gpt_dual_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                         pclk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            cnt_clk,
  input logic [NUM_CH-1:0]            wrap_pulse,
  input logic [NUM_CH-1:0]            clr_req,
  input logic [NUM_CH-1:0]            status,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_val,
  input logic [NUM_CH-1:0][CNT_W-1:0] reload_q,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0]            halt_q,
  input logic [NUM_CH-1:0]            wrap_tgl
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6: arriving wrap beats a clear in the same cycle
    a_r6_set_wins: assert property (@(posedge pclk) disable iff (!rst_n)
      (wrap_pulse[c] && clr_req[c]) |=> status[c]);

    // R5: a clear with no wrap drops the bit
    a_r5_clear_takes: assert property (@(posedge pclk) disable iff (!rst_n)
      (clr_req[c] && !wrap_pulse[c]) |=> !status[c]);

    // R5: no wrap and no clear means the bit holds
    a_r5_status_hold: assert property (@(posedge pclk) disable iff (!rst_n)
      (!clr_req[c] && !wrap_pulse[c]) |=> $stable(status[c]));

    // R3: counter never passes the reload value while running
    a_r3_count_bound: assert property (@(posedge cnt_clk[c]) disable iff (!rst_n)
      (run_q[c] && $stable(reload_q[c])) |-> (cnt_val[c] <= reload_q[c]));

    // R3: a wrap leaves the counter at zero
    a_r3_wrap_to_zero: assert property (@(posedge cnt_clk[c]) disable iff (!rst_n)
      !$stable(wrap_tgl[c]) |-> (cnt_val[c] == '0));

    // R7: a finished one-shot channel produces no further wraps
    a_r7_oneshot_quiet: assert property (@(posedge cnt_clk[c]) disable iff (!rst_n)
      (run_q[c] && halt_q[c]) |=> $stable(wrap_tgl[c]));
  end
endmodule

bind gpt_dual_timer gpt_dual_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .pclk      (pclk),
  .rst_n     (rst_n),
  .cnt_clk   (cnt_clk),
  .wrap_pulse(wrap_pulse),
  .clr_req   (clr_req),
  .status    (status_q),
  .cnt_val   (cnt_val),
  .reload_q  (reload_q),
  .run_q     (run_q),
  .halt_q    (halt_q),
  .wrap_tgl  (wrap_tgl)
);

// File: tb/gpt_dual_timer_bench.sv
`timescale 1ns/1ps
module gpt_dual_timer_bench;
  logic pclk = 1'b0;
  logic c1   = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 pclk = ~pclk;
  always #3.5 c1 = ~c1;

  logic [1:0]  cnt_clk;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [1:0]  irq;

  assign cnt_clk = {c1, pclk};   // channel 0 shares the bus clock, channel 1 is asynchronous

  gpt_dual_timer u_gpt_dual_timer (
    .pclk(pclk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .cnt_clk(cnt_clk), .irq(irq)
  );

  localparam logic [5:0] A_STAT = 6'h20;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int last_wr_cyc = 0;
  bit raw_rd = 1'b0;
  logic [31:0] raw_val;

  always @(posedge pclk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } rd_item_t;
  rd_item_t rdq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compares every scoreboarded read in its access phase
  always @(negedge pclk) begin
    #1;
    if (psel && penable && !pwrite && !raw_rd && rdq.size() > 0) begin
      rd_item_t it;
      it = rdq.pop_front();
      check((prdata & it.mask) == it.exp, it.tag, "read", longint'(prdata & it.mask), longint'(it.exp));
    end
  end

  task automatic apb_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    last_wr_cyc = cyc;
  endtask

  task automatic apb_read_exp(input logic [5:0] a, input logic [31:0] e,
                              input logic [31:0] m, input string tag);
    rd_item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    rdq.push_back(it);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic apb_read_raw(input logic [5:0] a, output logic [31:0] v);
    raw_rd = 1;
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    #1 v = prdata;
    @(negedge pclk); psel = 0; penable = 0;
    raw_rd = 0;
  endtask

  task automatic wait_irq(input int ch, input int max_cyc, output bit ok, output realtime t);
    ok = 0; t = 0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge pclk);
      if (irq[ch]) begin ok = 1; t = $realtime; break; end
    end
  endtask

  task automatic rate_test(input int ch, input int code, input int rel,
                           input real exp_ns, input string req);
    bit ok1, ok2;
    realtime t1, t2;
    logic [5:0] base;
    base = 6'(ch * 16);
    apb_write(base, 0);
    repeat (6) @(negedge pclk);
    apb_write(base + 6'h4, 32'(code));
    apb_write(base + 6'h8, 32'(rel));
    apb_write(A_STAT, 32'h3);
    apb_write(base, 32'h1);
    wait_irq(ch, 4000, ok1, t1);
    apb_write(A_STAT, 32'(1 << ch));
    wait_irq(ch, 4000, ok2, t2);
    check(ok1 && ok2, req, "wrap seen", longint'(ok1 && ok2), 1);
    check((t2 - t1) > exp_ns - 6.0 && (t2 - t1) < exp_ns + 6.0, req, "period ns",
          longint'(t2 - t1), longint'(exp_ns));
    apb_write(base, 0);
    repeat (6) @(negedge pclk);
    apb_write(A_STAT, 32'h3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit ok;
    realtime t;
    int offset, e_cyc;
    logic [31:0] v;
    repeat (4) @(negedge pclk);
    rst_n = 1;
    repeat (2) @(negedge pclk);

    // R1: reset state
    check(irq == 2'b00, "R1", "irq after reset", longint'(irq), 0);
    apb_read_exp(6'h00, 0, 32'hFFFF_FFFF, "R1");
    apb_read_exp(6'h04, 0, 32'hFFFF_FFFF, "R1");
    apb_read_exp(6'h08, 0, 32'hFFFF_FFFF, "R1");
    apb_read_exp(6'h0C, 0, 32'hFFFF_FFFF, "R1");
    apb_read_exp(6'h10, 0, 32'hFFFF_FFFF, "R1");
    apb_read_exp(A_STAT, 0, 32'hFFFF_FFFF, "R1");
    check(pready == 1'b1, "R11", "pready", longint'(pready), 1);

    // R2: register map, field widths, read-only count, unmapped
    apb_write(6'h10, 32'hFFFF_FFFC);
    apb_read_exp(6'h10, 0, 32'hFFFF_FFFF, "R2");
    apb_write(6'h04, 32'hFF);
    apb_read_exp(6'h04, 32'hF, 32'hFFFF_FFFF, "R2");
    apb_write(6'h08, 32'h12345);
    apb_write(6'h18, 32'hBEEF);
    apb_read_exp(6'h08, 32'h2345, 32'hFFFF_FFFF, "R2");
    apb_read_exp(6'h18, 32'hBEEF, 32'hFFFF_FFFF, "R2");
    apb_write(6'h0C, 32'h55);
    apb_read_exp(6'h0C, 0, 32'hFFFF_FFFF, "R2");
    apb_read_exp(6'h24, 0, 32'hFFFF_FFFF, "R2");

    // R3: wrap period for several codes and reloads
    rate_test(0, 0, 4, 50.0, "R3");
    rate_test(0, 2, 3, 160.0, "R3");
    // R4: reserved code behaves as /256
    rate_test(0, 9, 1, 2560.0, "R4");
    // R9: asynchronous channel 1, channel 0 untouched
    rate_test(1, 1, 9, 280.0, "R9");
    apb_read_exp(6'h0C, 0, 32'hFFFF_FFFF, "R9");

    // R7: one-shot stops at zero, then re-arms
    apb_write(6'h04, 0);
    apb_write(6'h08, 2);
    apb_write(6'h00, 32'h3);
    wait_irq(0, 200, ok, t);
    check(ok, "R7", "one-shot first wrap", longint'(ok), 1);
    apb_write(A_STAT, 32'h1);
    repeat (60) @(negedge pclk);
    check(irq[0] == 1'b0, "R7", "no second wrap", longint'(irq[0]), 0);
    apb_read_exp(6'h0C, 0, 32'hFFFF_FFFF, "R7");
    apb_write(6'h00, 0);
    repeat (6) @(negedge pclk);
    apb_write(6'h00, 32'h3);
    wait_irq(0, 200, ok, t);
    check(ok, "R7", "re-armed wrap", longint'(ok), 1);

    // R5: write-one-to-clear only touches written bits
    apb_write(A_STAT, 32'h2);
    apb_read_exp(A_STAT, 32'h1, 32'hFFFF_FFFF, "R5");
    check(irq[0] == 1'b1, "R5", "irq0 kept", longint'(irq[0]), 1);
    apb_write(A_STAT, 32'h1);
    apb_read_exp(A_STAT, 0, 32'hFFFF_FFFF, "R5");
    check(irq[0] == 1'b0, "R5", "irq0 cleared", longint'(irq[0]), 0);
    apb_write(6'h00, 0);
    repeat (6) @(negedge pclk);

    // R6: calibrate set cycle, then sweep the clear around it
    apb_write(6'h08, 3);
    apb_write(6'h00, 32'h3);
    e_cyc = last_wr_cyc;
    wait_irq(0, 200, ok, t);
    offset = cyc - e_cyc;
    check(ok, "R6", "calibration wrap", longint'(ok), 1);
    apb_write(6'h00, 0);
    apb_write(A_STAT, 32'h1);
    repeat (6) @(negedge pclk);
    for (int k = offset - 2; k <= offset + 2; k++) begin
      int exp_bit;
      apb_write(6'h00, 32'h3);
      e_cyc = last_wr_cyc;
      repeat (k - 3) @(negedge pclk);
      apb_write(A_STAT, 32'h1);
      exp_bit = (last_wr_cyc <= e_cyc + offset) ? 1 : 0;
      repeat (30) @(negedge pclk);
      apb_read_exp(A_STAT, 32'(exp_bit), 32'h1, "R6");
      apb_write(6'h00, 0);
      apb_write(A_STAT, 32'h1);
      repeat (6) @(negedge pclk);
    end

    // R10: live count readback, R8: disable zeroes the counter
    apb_write(6'h08, 32'hFFFF);
    apb_write(6'h00, 32'h1);
    repeat (200) @(negedge pclk);
    apb_read_raw(6'h0C, v);
    check(v >= 95 && v <= 101, "R10", "count readback", longint'(v), 99);
    apb_write(6'h00, 0);
    repeat (8) @(negedge pclk);
    apb_read_exp(6'h0C, 0, 32'hFFFF_FFFF, "R8");
    apb_write(6'h00, 32'h1);
    repeat (20) @(negedge pclk);
    apb_read_raw(6'h0C, v);
    check(v >= 6 && v <= 10, "R8", "fresh count after re-enable", longint'(v), 9);
    apb_write(6'h00, 0);

    repeat (10) @(negedge pclk);
    check(rdq.size() == 0, "R2", "scoreboard drained", longint'(rdq.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule